// File: doc/BRIEF.md
# PHY Test-Port Configuration Sequencer

This block brings a serial-link PHY out of reset. First it writes a small set of tuning values into the PHY's internal registers. The PHY exposes those registers only through a narrow test port: a 32-bit word driven into the PHY, and a 32-bit word read back from it. The block frames every test-port access itself. Each access drives the word and then issues the trailing read strobes that the port demands. Each tuning update is wrapped in a pre-read, a three-step write-enable pulse and a dummy read.

After the last tuning update the block waits a settle time and then releases the PHY reset in manual mode. It waits the same settle time again before it reports completion. A separate stop request returns the reset control word to manual mode with the reset asserted. The system controller uses a one-cycle start or stop pulse, watches `busy`, and takes the one-cycle `done` pulse as the end of the sequence.

Top module: `phy_tune_seq`

## Requirements
- R1: While reset is held and after it is released, until the first request, `busy`, `done` and `tp_strobe` are low, and `tp_drive` and `phy_rst_ctl` are zero.
- R2: `tp_drive` packs three fields: an 8-bit data field in bits 13:6, a 5-bit register address in bits 5:1, and a write-enable flag in bit 0. Bits 31:14 are always zero.
- R3: After each new `tp_drive` value, one cycle passes with no strobe. Then come single-cycle `tp_strobe` pulses separated by low cycles, and `tp_drive` does not change from one cycle before a strobe until that strobe ends. A pre-read access and a dummy-read access each get three strobes. Every other access gets two.
- R4: Each tuning update issues five accesses in this order. (1) A pre-read: data 1, target address, write-enable 0. (2) The write word with write-enable 0. (3) The same word with write-enable 1. (4) The same word with write-enable 0. (5) A dummy read: data 1, same address.
- R5: Updates run in a fixed order. Register 0 first, mask 0x08, value 0x08. Then register 6, mask 0x3F, value `EQ_ADJ_VAL`, default 0. Then register 26, mask 0xF0, value `VCO_VAL` in bits 7:4, default 5, which gives 0x50.
- R6: The write data is `mask & value` when `KEEP_UNMASKED` is 0, whatever the PHY returns. When `KEEP_UNMASKED` is 1, the write data is `(cap & ~mask) | (mask & value)`. Here `cap` is bits 7:0 of `tp_sample`, captured at the third strobe of the pre-read.
- R7: `phy_rst_ctl` stays unchanged during the tuning accesses. It becomes 0x101 (bit 8 = manual mode, bit 0 = reset released) in the cycle that comes `DELAY_CYCLES`+2 cycles after the last strobe cycle.
- R8: `done` is a single-cycle pulse that goes high `DELAY_CYCLES` cycles after the release appears. `busy` is high from the cycle after the start pulse until the cycle in which `done` is high, and low in that cycle.
- R9: A stop pulse while idle gives one busy cycle. In the next cycle `done` is high, `busy` is low and `phy_rst_ctl` is 0x100.
- R10: Start and stop pulses that arrive while busy are ignored: exactly one sequence runs, it ends with 0x101, and `done` pulses once. If start and stop arrive together while idle, the stop wins.
- R11: `tp_strobe` is never high and `tp_drive` is zero while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to run the tuning and release sequence |
| stop | input | 1 | One-cycle request to put the PHY back into manual reset |
| tp_sample | input | 32 | Test-output word from the PHY; bits 7:0 carry read data |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle completion pulse |
| tp_drive | output | 32 | Test-input word to the PHY |
| tp_strobe | output | 1 | Test-output read strobe |
| phy_rst_ctl | output | 32 | PHY reset control word (bit 8 manual mode, bit 0 release) |

## Verification
The assertions check the framing rules of the port on every cycle. They check the single-cycle strobe and that `tp_drive` stays stable around each strobe. They also check that strobes happen only while busy, that `done` is a pulse seen only with `busy` low, that busy ends only through `done`, and that the release bit never appears without the manual-mode bit. Other behaviours can only be shown by the bench's scenarios, which compare the full ordered list of strobed words against expected values: the exact access order and field values, the merge with the read-back byte, the settle counts before and after release, and the handling of requests that arrive while busy.

// File: rtl/phy_tune_seq.sv
module phy_tune_seq #(
  parameter int         DELAY_CYCLES  = 125,
  parameter bit         KEEP_UNMASKED = 1'b0,
  parameter logic [5:0] EQ_ADJ_VAL    = 6'd0,
  parameter logic [3:0] VCO_VAL       = 4'd5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        stop,
  input  logic [31:0] tp_sample,
  output logic        busy,
  output logic        done,
  output logic [31:0] tp_drive,
  output logic        tp_strobe,
  output logic [31:0] phy_rst_ctl
);

  localparam int CW = $clog2(DELAY_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(DELAY_CYCLES - 1);
  localparam logic [1:0] LAST_PARAM = 2'd2;
  localparam logic [2:0] LAST_ACC = 3'd4;

  typedef enum logic [2:0] {S_IDLE, S_ACC, S_SETTLE, S_HOLD, S_EXIT} state_t;

  state_t        state;
  logic [1:0]    pi;
  logic [2:0]    ai;
  logic [2:0]    st;
  logic [CW-1:0] cnt;
  logic [7:0]    cap;
  logic          man_q, rel_q, done_q;

  function automatic logic [4:0] p_addr(input logic [1:0] p);
    case (p)
      2'd0:    return 5'd0;
      2'd1:    return 5'd6;
      default: return 5'd26;
    endcase
  endfunction

  function automatic logic [7:0] p_mask(input logic [1:0] p);
    case (p)
      2'd0:    return 8'h08;
      2'd1:    return 8'h3F;
      default: return 8'hF0;
    endcase
  endfunction

  function automatic logic [7:0] p_val(input logic [1:0] p);
    case (p)
      2'd0:    return 8'h08;
      2'd1:    return {2'b00, EQ_ADJ_VAL};
      default: return {VCO_VAL, 4'h0};
    endcase
  endfunction

  logic       rd_acc;
  logic       last_step;
  logic [7:0] wdata;
  logic [7:0] dfield;
  logic       unused_hi;

  assign rd_acc    = (ai == 3'd0) || (ai == LAST_ACC);
  assign last_step = (st == (rd_acc ? 3'd6 : 3'd4));

  generate
    if (KEEP_UNMASKED) begin : g_merge
      assign wdata = (cap & ~p_mask(pi)) | (p_mask(pi) & p_val(pi));
    end else begin : g_plain
      assign wdata = p_mask(pi) & p_val(pi);
    end
  endgenerate

  assign dfield    = rd_acc ? 8'd1 : wdata;
  assign tp_drive  = (state == S_ACC) ? {18'b0, dfield, p_addr(pi), (ai == 3'd2)} : 32'b0;
  assign tp_strobe = (state == S_ACC) && st[0];
  assign busy      = (state != S_IDLE);
  assign done      = done_q;
  assign phy_rst_ctl = {23'b0, man_q, 7'b0, rel_q};
  assign unused_hi = ^tp_sample[31:8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap <= 8'h00;
    end else if (state == S_ACC && ai == 3'd0 && st == 3'd5) begin
      cap <= tp_sample[7:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      pi     <= 2'd0;
      ai     <= 3'd0;
      st     <= 3'd0;
      cnt    <= '0;
      man_q  <= 1'b0;
      rel_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        S_IDLE: begin
          if (stop) begin
            state <= S_EXIT;
          end else if (start) begin
            state <= S_ACC;
            pi    <= 2'd0;
            ai    <= 3'd0;
            st    <= 3'd0;
          end
        end
        S_ACC: begin
          if (last_step) begin
            st <= 3'd0;
            if (ai == LAST_ACC) begin
              ai <= 3'd0;
              if (pi == LAST_PARAM) begin
                state <= S_SETTLE;
                cnt   <= CNT_LOAD;
              end else begin
                pi <= pi + 2'd1;
              end
            end else begin
              ai <= ai + 3'd1;
            end
          end else begin
            st <= st + 3'd1;
          end
        end
        S_SETTLE: begin
          if (cnt == '0) begin
            man_q <= 1'b1;
            rel_q <= 1'b1;
            cnt   <= CNT_LOAD;
            state <= S_HOLD;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_HOLD: begin
          if (cnt == '0) begin
            done_q <= 1'b1;
            state  <= S_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_EXIT: begin
          man_q  <= 1'b1;
          rel_q  <= 1'b0;
          done_q <= 1'b1;
          state  <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/phy_tune_seq_chk.sv
module phy_tune_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        stop,
  input logic        busy,
  input logic        done,
  input logic [31:0] tp_drive,
  input logic        tp_strobe,
  input logic [31:0] phy_rst_ctl
);

  // R3
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tp_strobe |=> !tp_strobe);

  // R3
  drive_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tp_strobe |-> $stable(tp_drive));

  // R2
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tp_drive[31:14] == 18'b0);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!tp_strobe && tp_drive == 32'b0));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy ##1 !done));

  // R8
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R7
  release_manual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phy_rst_ctl[0] |-> phy_rst_ctl[8]);

  // R9
  idle_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (start || stop)) |=> busy);

endmodule

bind phy_tune_seq phy_tune_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .busy(busy),
  .done(done), .tp_drive(tp_drive), .tp_strobe(tp_strobe),
  .phy_rst_ctl(phy_rst_ctl)
);

// File: tb/phy_tune_seq_tb.sv
module phy_tune_seq_tb;
  localparam int D = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic stop = 1'b0;
  always #4 clk = ~clk;

  logic [31:0] a_drive, k_drive, a_ctl, k_ctl, a_samp, k_samp;
  logic a_rd, k_rd, a_busy, k_busy, a_done, k_done;
  logic [7:0]  rb [0:31];
  logic [23:0] hi = 24'h0;

  assign a_samp = {hi, rb[a_drive[5:1]]};
  assign k_samp = {hi, rb[k_drive[5:1]]};

  phy_tune_seq #(.DELAY_CYCLES(D)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .tp_sample(a_samp),
    .busy(a_busy), .done(a_done), .tp_drive(a_drive), .tp_strobe(a_rd),
    .phy_rst_ctl(a_ctl));

  phy_tune_seq #(.DELAY_CYCLES(D), .KEEP_UNMASKED(1'b1)) u_keep (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .tp_sample(k_samp),
    .busy(k_busy), .done(k_done), .tp_drive(k_drive), .tp_strobe(k_rd),
    .phy_rst_ctl(k_ctl));

  int nchk = 0, nfail = 0, wd = 0;
  int cyc = 0, na = 0, nk = 0, last_rd = 0, rel_cyc = 0, done_cyc = 0, done_cnt = 0, viol = 0;
  logic [31:0] la [0:63];
  logic [31:0] lk [0:63];
  logic [31:0] prev_in = 32'h0;
  logic prev_rd = 1'b0, prev_rel = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input int p, input int a, input bit keep, input logic [7:0] rbv);
    logic [4:0] ad;
    logic [7:0] m, v, w, d;
    ad = (p == 0) ? 5'd0 : (p == 1) ? 5'd6 : 5'd26;
    m  = (p == 0) ? 8'h08 : (p == 1) ? 8'h3F : 8'hF0;
    v  = (p == 0) ? 8'h08 : (p == 1) ? 8'h00 : 8'h50;
    w  = keep ? ((rbv & ~m) | (m & v)) : (m & v);
    d  = (a == 0 || a == 4) ? 8'd1 : w;
    return {18'b0, d, ad, (a == 2)};
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (a_rd) begin
        if (na < 64) la[na] = a_drive;
        na++;
        last_rd = cyc;
        if (prev_rd || a_drive != prev_in || !a_busy || a_ctl[0]) viol++;
      end
      if (k_rd) begin
        if (nk < 64) lk[nk] = k_drive;
        nk++;
      end
      if (!a_busy && (a_rd || a_drive != 32'h0)) viol++;
      if (a_ctl[0] && !prev_rel) rel_cyc = cyc;
      if (a_done) begin
        done_cnt++;
        done_cyc = cyc;
        if (a_busy) viol++;
      end
      prev_rd  = a_rd;
      prev_in  = a_drive;
      prev_rel = a_ctl[0];
    end
  end

  always @(negedge clk) begin
    wd++;
    if (wd > 150000) begin
      nfail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", wd, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
      $finish;
    end
  end

  task automatic do_stop();
    @(negedge clk); #1 stop = 1'b1;
    @(negedge clk);
    chk(a_busy && !a_done, "R9 busy cycle after stop", {30'b0, a_busy, a_done}, 32'h2);
    #1 stop = 1'b0;
    @(negedge clk);
    chk(a_done && !a_busy && a_ctl == 32'h100, "R9 manual reset word", a_ctl, 32'h100);
    chk(k_ctl == 32'h100, "R9 manual reset word keep", k_ctl, 32'h100);
  endtask

  task automatic do_init();
    int w, gap, idx;
    bit seen;
    #1;
    na = 0; nk = 0; done_cnt = 0; viol = 0; gap = 0; seen = 0;
    start = 1'b1;
    @(negedge clk);
    chk(a_busy && !a_rd && a_drive == exp_word(0, 0, 0, 8'h0), "R3 first access hold", a_drive, exp_word(0, 0, 0, 8'h0));
    #1 start = 1'b0;
    w = $urandom_range(120, 2);
    for (int i = 0; i < w; i++) begin
      @(negedge clk);
      if (!a_busy) gap++;
    end
    #1 start = 1'b1; stop = 1'b1;
    @(negedge clk);
    #1 start = 1'b0; stop = 1'b0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (a_done) begin seen = 1; break; end
      if (!a_busy) gap++;
    end
    @(negedge clk); #1;
    chk(seen, "R8 done seen", {31'b0, seen}, 32'h1);
    chk(gap == 0, "R8 busy held", gap, 0);
    chk(done_cnt == 1, "R10 single done", done_cnt, 1);
    chk(viol == 0, "R3 R11 framing", viol, 0);
    chk(na == 36, "R4 strobe count", na, 36);
    chk(nk == 36, "R6 strobe count keep", nk, 36);
    idx = 0;
    for (int p = 0; p < 3; p++) begin
      for (int a = 0; a < 5; a++) begin
        for (int r = 0; r < ((a == 0 || a == 4) ? 3 : 2); r++) begin
          logic [7:0] rbv;
          rbv = rb[(p == 0) ? 0 : (p == 1) ? 6 : 26];
          if (idx < na) chk(la[idx] == exp_word(p, a, 0, rbv), "R4 R5 R2 word", la[idx], exp_word(p, a, 0, rbv));
          if (idx < nk) chk(lk[idx] == exp_word(p, a, 1, rbv), "R6 merged word", lk[idx], exp_word(p, a, 1, rbv));
          idx++;
        end
      end
    end
    chk(rel_cyc - last_rd == D + 2, "R7 release delay", rel_cyc - last_rd, D + 2);
    chk(done_cyc - rel_cyc == D, "R8 done delay", done_cyc - rel_cyc, D);
    chk(a_ctl == 32'h101 && k_ctl == 32'h101, "R10 stop ignored, released", a_ctl, 32'h101);
  endtask

  initial begin
    void'($urandom(32'h1f2e3d4c));
    for (int i = 0; i < 32; i++) rb[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk(!a_busy && !a_done && !a_rd && a_drive == 0 && a_ctl == 0, "R1 in reset", a_ctl, 0);
    #1 rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!a_busy && !a_done && !a_rd && a_drive == 0 && a_ctl == 0, "R1 after reset", a_drive, 0);

    for (int it = 0; it < 6; it++) begin
      #1;
      for (int i = 0; i < 32; i++)
        rb[i] = (it == 0) ? 8'hFF : (it == 1) ? 8'h00 : 8'($urandom);
      hi = 24'($urandom);
      do_stop();
      do_init();
    end

    #1;
    na = 0; done_cnt = 0;
    start = 1'b1; stop = 1'b1;
    @(negedge clk);
    #1 start = 1'b0; stop = 1'b0;
    @(negedge clk);
    chk(a_ctl == 32'h100 && a_done, "R10 stop wins in idle", a_ctl, 32'h100);
    repeat (20) @(negedge clk);
    chk(na == 0 && !a_busy, "R10 R11 no accesses after stop", na, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule